// File: doc/BRIEF.md
# Register-Controlled GPIO Bank with Per-Pin Interrupts

This block is a bank of up to 32 general-purpose pins that software reaches through a small 32-bit register interface with word-aligned addresses. Every register holds one bit per pin. For each pin, software sets whether the pin is sampled, whether it is driven, the value it drives, and a polarity-flip mask that is applied to that value on the way out.

Each incoming pin level passes through a two-flop synchroniser. The synchronised level feeds four independent trigger detectors: rising edge, falling edge, level high and level low. Each trigger kind has its own enable register and its own sticky pending register. Software clears a pending bit by writing a one to it. Each pin drives its own interrupt line, which is the OR of its enabled pending bits.

The block is meant to sit behind a bus bridge. Pads, pull resistors and pin multiplexing are handled outside it.

Top module: `gpio_bank`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, every enable register, every pending register, `pin_oe`, `pin_out` and `pin_irq` are zero.
- R2: The word offsets are 0x00 synchronised input level (read-only), 0x04 input enable, 0x08 output enable, 0x0C output value, 0x40 output flip mask. Trigger pairs (enable, pending) sit at 0x18/0x1C rise, 0x20/0x24 fall, 0x28/0x2C high, 0x30/0x34 low. Bit i of each register belongs to pin i. Any other offset reads zero, and writes to 0x00 or to an unmapped offset change nothing. The control registers and enables read back the last value written, and 0x0C returns the written value, not the pin level.
- R3: Offset 0x00 reads the pin level delayed by two clock edges through the synchroniser, ANDed with the input enable.
- R4: `pin_out` equals output value XOR flip mask, and `pin_oe` equals the output enable register. Both change only after a register write.
- R5: A rising (falling) pending bit sets on the third clock edge after the pin goes from 0 to 1 (1 to 0), because the edge is found by comparing the synchronised level with its value one cycle earlier.
- R6: A high (low) pending bit is set on every clock edge at which the synchronised level is 1 (0), whatever the enable.
- R7: Pending bits are sticky and stay set after the condition goes away.
- R8: Writing a one to a pending bit clears it and writing a zero leaves it unchanged.
- R9: If a trigger condition holds at the same edge as a write-one-to-clear, the bit stays set.
- R10: `pin_irq[i]` is the OR over the four kinds of (pending bit i AND enable bit i), and it follows register state within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Raw asynchronous pin levels |
| pin_out | output | NPINS | Value driven on each pin |
| pin_oe | output | NPINS | Drive enable for each pin |
| pin_irq | output | NPINS | Per-pin interrupt lines |

## Verification
The bench targets three things. It measures the exact edge at which input reads and edge-pending bits appear; a synchroniser one flop short or long moves that edge by a cycle. It aims a clear at a level condition that is still active; a design that lets the clear win would show the bit empty for a cycle. It writes zero to pending registers; a design that treated the write as a plain store would wipe bits that should persist. Enables are turned on and off over pending bits to show that the interrupt masks without consuming pending state. A random phase of writes and pin changes checks every output against a behavioural model on every cycle.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_irq
);
  localparam int KINDS = 4;
  localparam logic [AW-1:0] A_LVL  = AW'('h00);
  localparam logic [AW-1:0] A_IEN  = AW'('h04);
  localparam logic [AW-1:0] A_OEN  = AW'('h08);
  localparam logic [AW-1:0] A_OVAL = AW'('h0C);
  localparam logic [AW-1:0] A_FLIP = AW'('h40);
  localparam logic [AW-1:0] EN_OFF [KINDS] = '{AW'('h18), AW'('h20), AW'('h28), AW'('h30)};

  logic [NPINS-1:0] meta_q, sync_q, prev_q;
  logic [NPINS-1:0] in_en_q, out_en_q, out_val_q, flip_q;
  logic [KINDS-1:0][NPINS-1:0] ie_q, ip_q, hit;
  logic [NPINS-1:0] wd;

  assign wd = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      out_val_q <= '0;
      flip_q    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_IEN)  in_en_q   <= wd;
      if (bus_addr == A_OEN)  out_en_q  <= wd;
      if (bus_addr == A_OVAL) out_val_q <= wd;
      if (bus_addr == A_FLIP) flip_q    <= wd;
    end
  end

  assign hit[0] = sync_q & ~prev_q;
  assign hit[1] = ~sync_q & prev_q;
  assign hit[2] = sync_q;
  assign hit[3] = ~sync_q;

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    logic [NPINS-1:0] clr;
    assign clr = (bus_wr && bus_addr == EN_OFF[k] + AW'(4)) ? wd : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ie_q[k] <= '0;
        ip_q[k] <= '0;
      end else begin
        if (bus_wr && bus_addr == EN_OFF[k]) ie_q[k] <= wd;
        ip_q[k] <= (ip_q[k] & ~clr) | hit[k];
      end
    end
  end

  assign pin_irq = (ip_q[0] & ie_q[0]) | (ip_q[1] & ie_q[1])
                 | (ip_q[2] & ie_q[2]) | (ip_q[3] & ie_q[3]);
  assign pin_out = out_val_q ^ flip_q;
  assign pin_oe  = out_en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LVL:   bus_rdata[NPINS-1:0] = sync_q & in_en_q;
      A_IEN:   bus_rdata[NPINS-1:0] = in_en_q;
      A_OEN:   bus_rdata[NPINS-1:0] = out_en_q;
      A_OVAL:  bus_rdata[NPINS-1:0] = out_val_q;
      A_FLIP:  bus_rdata[NPINS-1:0] = flip_q;
      default: ;
    endcase
    for (int k = 0; k < KINDS; k++) begin
      if (bus_addr == EN_OFF[k])          bus_rdata[NPINS-1:0] = ie_q[k];
      if (bus_addr == EN_OFF[k] + AW'(4)) bus_rdata[NPINS-1:0] = ip_q[k];
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [NPINS-1:0]       pin_out,
  input logic [NPINS-1:0]       pin_oe,
  input logic [NPINS-1:0]       pin_irq,
  input logic [NPINS-1:0]       sync_q,
  input logic [NPINS-1:0]       prev_q,
  input logic [3:0][NPINS-1:0]  ie_q,
  input logic [3:0][NPINS-1:0]  ip_q
);
  localparam logic [AW-1:0] PEND [4] = '{AW'('h1C), AW'('h24), AW'('h2C), AW'('h34)};

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (ie_q == '0 && ip_q == '0 && pin_irq == '0 && pin_oe == '0));

  a_r4_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_wr) && $past(rst_n)) |-> ($stable(pin_out) && $stable(pin_oe)));

  a_r6_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((ip_q[2] & $past(sync_q)) == $past(sync_q)));

  a_r6_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((ip_q[3] & ~$past(sync_q)) == ~$past(sync_q)));

  a_r8_rise_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == PEND[0]) |->
      ((ip_q[0] & $past(bus_wdata[NPINS-1:0]) & ~$past(sync_q & ~prev_q)) == '0));

  a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> (pin_irq == '0));

  for (genvar k = 0; k < 4; k++) begin : g_sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !($past(bus_wr) && $past(bus_addr) == PEND[k])) |->
        ((ip_q[k] & $past(ip_q[k])) == $past(ip_q[k])));
  end
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq),
  .sync_q(sync_q), .prev_q(prev_q), .ie_q(ie_q), .ip_q(ip_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_irq;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  gpio_bank #(.NPINS(32), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] m_s1, m_s2, m_prev, m_ien, m_oen, m_oval, m_flip;
  logic [31:0] m_ie [4];
  logic [31:0] m_ip [4];
  int base_of [4] = '{'h18, 'h20, 'h28, 'h30};

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r;
    r = 0;
    case (a)
      8'h00: r = m_s2 & m_ien;
      8'h04: r = m_ien;
      8'h08: r = m_oen;
      8'h0C: r = m_oval;
      8'h40: r = m_flip;
      default: ;
    endcase
    for (int k = 0; k < 4; k++) begin
      if (int'(a) == base_of[k])     r = m_ie[k];
      if (int'(a) == base_of[k] + 4) r = m_ip[k];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_ien = 0; m_oen = 0; m_oval = 0; m_flip = 0;
      for (int k = 0; k < 4; k++) begin m_ie[k] = 0; m_ip[k] = 0; end
    end else begin
      logic [31:0] cond [4];
      cond[0] = m_s2 & ~m_prev;
      cond[1] = ~m_s2 & m_prev;
      cond[2] = m_s2;
      cond[3] = ~m_s2;
      for (int k = 0; k < 4; k++) begin
        if (bus_wr && int'(bus_addr) == base_of[k] + 4) m_ip[k] = m_ip[k] & ~bus_wdata;
        m_ip[k] = m_ip[k] | cond[k];
        if (bus_wr && int'(bus_addr) == base_of[k]) m_ie[k] = bus_wdata;
      end
      if (bus_wr) begin
        if (bus_addr == 8'h04) m_ien = bus_wdata;
        if (bus_addr == 8'h08) m_oen = bus_wdata;
        if (bus_addr == 8'h0C) m_oval = bus_wdata;
        if (bus_addr == 8'h40) m_flip = bus_wdata;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [31:0] irq_exp;
      irq_exp = 0;
      for (int k = 0; k < 4; k++) irq_exp |= m_ip[k] & m_ie[k];
      check(pin_out, m_oval ^ m_flip, "R4 model pin_out");
      check(pin_oe, m_oen, "R4 model pin_oe");
      check(pin_irq, irq_exp, "R10 model pin_irq");
      check(bus_rdata, m_read(bus_addr), "R2 model read");
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    check(bus_rdata, exp, tag);
    tick();
  endtask

  task automatic irq_chk(input logic [31:0] exp, input string tag);
    @(negedge clk);
    check(pin_irq, exp, tag);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) tick();
    @(negedge clk);
    check(pin_irq, 32'h0, "R1 irq in reset");
    check(pin_oe, 32'h0, "R1 oe in reset");
    tick();
    rst_n = 1'b1;
    cmp_on = 1'b1;
    rd_chk(8'h18, 0, "R1 rise enable");
    rd_chk(8'h20, 0, "R1 fall enable");
    rd_chk(8'h28, 0, "R1 high enable");
    rd_chk(8'h30, 0, "R1 low enable");
    rd_chk(8'h1C, 0, "R1 rise pending");

    wr(8'h0C, 32'hA5A5_0F0F);
    wr(8'h40, 32'hFFFF_0000);
    wr(8'h08, 32'h00FF_FF00);
    @(negedge clk);
    check(pin_out, 32'h5A5A_0F0F, "R4 flipped output");
    check(pin_oe, 32'h00FF_FF00, "R4 drive enable");
    tick();
    rd_chk(8'h0C, 32'hA5A5_0F0F, "R2 output value readback");
    rd_chk(8'h40, 32'hFFFF_0000, "R2 flip readback");

    wr(8'h04, 32'h0000_FFFF);
    pin_in = 32'h1234_5678;
    rd_chk(8'h00, 0, "R3 level before first edge");
    rd_chk(8'h00, 0, "R3 level after one edge");
    rd_chk(8'h00, 32'h0000_5678, "R3 level after two edges");
    repeat (3) tick();

    wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk(8'h1C, 0, "R8 rise cleared");
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_chk(8'h2C, 32'h1234_5678, "R9 high set wins over clear");

    pin_in = 32'h9234_5678;
    rd_chk(8'h1C, 0, "R5 rise edge 0");
    rd_chk(8'h1C, 0, "R5 rise edge 1");
    rd_chk(8'h1C, 0, "R5 rise edge 2");
    rd_chk(8'h1C, 32'h8000_0000, "R5 rise edge 3");
    pin_in = 32'h1234_5678;
    repeat (5) tick();
    rd_chk(8'h1C, 32'h8000_0000, "R7 rise sticky");
    rd_chk(8'h24, 32'h8000_0000, "R5 fall pending");
    rd_chk(8'h2C, 32'h9234_5678, "R6 high pending");

    wr(8'h1C, 32'h0);
    rd_chk(8'h1C, 32'h8000_0000, "R8 zero write keeps");
    wr(8'h1C, 32'h8000_0000);
    rd_chk(8'h1C, 0, "R8 one write clears");

    wr(8'h20, 32'h8000_0000);
    wr(8'h28, 32'h0000_0010);
    wr(8'h30, 32'h0000_0001);
    irq_chk(32'h8000_0011, "R10 enabled pending");
    wr(8'h20, 32'h0);
    irq_chk(32'h0000_0011, "R10 masked fall");
    rd_chk(8'h24, 32'h8000_0000, "R10 mask keeps pending");
    wr(8'h28, 32'h0);
    wr(8'h30, 32'h0);
    irq_chk(32'h0, "R10 all masked");

    rd_chk(8'h10, 0, "R2 unmapped reads zero");
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0000_5678, "R2 level register ignores writes");
    wr(8'h04, 32'h0);
    rd_chk(8'h00, 0, "R3 input enable masks");

    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [7:0] addrs [17] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                                 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h40, 8'h44};
      pick = int'($urandom_range(0, 16));
      bus_addr = addrs[pick];
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_wdata = $urandom();
      if ($urandom_range(0, 2) == 0) pin_in = $urandom();
      tick();
    end
    bus_wr = 1'b0;
    tick();
    finish_run();
  end
endmodule